// File: doc/BRIEF.md
# Split-Kernel Phase Sequencer

This block is the control state machine of a streaming 2D convolution engine whose compute core is an 8×8 weight-stationary array. A single start pulse captures the image side length N and the kernel side length K. The machine then walks through a load step and a kernel-streaming step. Next come convolution and writeback, and finally a drain step, before it reports completion. The memories and the array are separate sub-units. Each step hands off to its sub-unit and waits for that sub-unit's completion strobe before it moves on.

A kernel wider than the array is folded. It is split into 8×8 quadrants that are processed one after another, and the partial results are summed by the writeback logic. The sequencer decides how many quadrant passes are needed. It presents the active pass index, which the writeback logic uses as a byte-lane select, together with the kernel row and column offsets of that quadrant. It also gates convolution completion until the array input pipeline has filled. It reports the output side length N−K+1 for the drain logic.

Top module: `conv_phase_seq`

## Requirements
- R1: While reset is low and after it is released, state_o reads 0 (idle), and done, busy, res_valid, phase_idx, ker_row_off and ker_col_off all read 0.
- R2: A start seen in idle moves state_o to 1 (load) on the next clock edge and captures cfg_img_n and cfg_ker_k. A start in any other state, including the done cycle, is ignored: the state and the captured configuration are left unchanged.
- R3: The state codes are load=1, kernel stream=2, convolution=3, writeback=4, drain=5 and done=6. Load advances to kernel stream only on load_ack. Kernel stream advances to convolution only on kstr_ack. Writeback advances only on wb_ack. Drain advances to done only on drain_ack. An acknowledge belonging to another state has no effect.
- R4: res_valid rises exactly FILL_CYCLES (8) clock edges after state_o becomes 3. A conv_ack that arrives while res_valid is low is ignored. A conv_ack that arrives while res_valid is high moves the state to writeback.
- R5: When the captured K is 8 or less, n_phases reads 1 and a single pass runs with phase_idx 0 and both offsets 0. Writeback then goes to drain.
- R6: When the captured K is above 8, n_phases reads 4 and passes 0..3 run in this order: top-left (row 0, col 0), top-right (row 0, col 8), bottom-left (row 8, col 0), bottom-right (row 8, col 8). wb_ack on a pass other than the last returns to kernel stream with phase_idx incremented. phase_idx changes only on that transition or on a start.
- R7: drain_ack moves the machine to the done state. done is high for exactly that one cycle, and the machine then returns to idle.
- R8: out_dim reads N−K+1 when K≤N and 0 when K>N, computed from the values captured at start.
- R9: Driving rst_n low returns state_o to idle at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only in idle |
| cfg_img_n | input | 7 | Image side length N (up to 64) |
| cfg_ker_k | input | 5 | Kernel side length K (up to 16) |
| load_ack | input | 1 | Load sub-unit finished |
| kstr_ack | input | 1 | Kernel quadrant streamed into the array |
| conv_ack | input | 1 | Convolution pass finished |
| wb_ack | input | 1 | Partial results written back |
| drain_ack | input | 1 | Final results streamed out |
| state_o | output | 3 | Current state code |
| busy | output | 1 | High whenever not idle |
| res_valid | output | 1 | Array pipeline filled in the convolution state |
| phase_idx | output | 2 | Active quadrant pass / writeback byte lane |
| n_phases | output | 3 | Number of passes for the captured K |
| ker_row_off | output | 5 | Kernel row offset of the active quadrant |
| ker_col_off | output | 5 | Kernel column offset of the active quadrant |
| out_dim | output | 7 | Output side length |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same clock edge: a fresh start and the done pulse that closes the previous job. The bench raises start during the done cycle and expects idle on the next cycle, with no load state and with out_dim still showing the previous job's value. A second collision pairs an early conv_ack with the fill window. The ack is pulsed a few cycles into convolution, and the bench expects the state to hold at 3 until res_valid has risen on the eighth edge.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_LOAD  = 3'd1,
    SEQ_KSTR  = 3'd2,
    SEQ_CONV  = 3'd3,
    SEQ_WB    = 3'd4,
    SEQ_DRAIN = 3'd5,
    SEQ_DONE  = 3'd6
  } seq_state_e;

  localparam int unsigned QUAD_PHASES = 4;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/seq_cfg_latch.sv
module seq_cfg_latch #(
  parameter int unsigned NW        = 7,
  parameter int unsigned KW        = 5,
  parameter int unsigned ARRAY_DIM = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          capture,
  input  logic [NW-1:0] img_n,
  input  logic [KW-1:0] ker_k,
  output logic [2:0]    n_phases_o,
  output logic [NW-1:0] out_dim_o
);

  localparam int unsigned CW = (NW > KW) ? NW + 1 : KW + 1;

  logic [CW-1:0] n_ext, k_ext;
  logic [2:0]    phases_d;
  logic [NW-1:0] dim_d;

  always_comb begin
    n_ext    = CW'(img_n);
    k_ext    = CW'(ker_k);
    phases_d = (k_ext > CW'(ARRAY_DIM)) ? 3'd4 : 3'd1;
    if (k_ext > n_ext) begin
      dim_d = '0;
    end else begin
      dim_d = NW'(n_ext - k_ext + CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      n_phases_o <= 3'd1;
      out_dim_o  <= '0;
    end else if (capture) begin
      n_phases_o <= phases_d;
      out_dim_o  <= dim_d;
    end
  end

endmodule

// File: rtl/seq_phase_ctr.sv
module seq_phase_ctr #(
  parameter int unsigned ARRAY_DIM = 8,
  parameter int unsigned OFFW      = 5
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            clear,
  input  logic            advance,
  input  logic [2:0]      n_phases,
  output logic [1:0]      phase_o,
  output logic            last_o,
  output logic [OFFW-1:0] row_off_o,
  output logic [OFFW-1:0] col_off_o
);

  localparam bit DIM_POW2 = (ARRAY_DIM & (ARRAY_DIM - 1)) == 0;
  localparam int unsigned DIM_LOG = (ARRAY_DIM > 1) ? $clog2(ARRAY_DIM) : 0;

  logic [1:0] phase_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 2'd0;
    end else if (clear) begin
      phase_q <= 2'd0;
    end else if (advance) begin
      phase_q <= phase_q + 2'd1;
    end
  end

  assign phase_o = phase_q;
  assign last_o  = ({1'b0, phase_q} == (n_phases - 3'd1));

  generate
    if (DIM_POW2) begin : g_shift_off
      assign row_off_o = OFFW'({{(OFFW-1){1'b0}}, phase_q[1]} << DIM_LOG);
      assign col_off_o = OFFW'({{(OFFW-1){1'b0}}, phase_q[0]} << DIM_LOG);
    end else begin : g_mux_off
      assign row_off_o = phase_q[1] ? OFFW'(ARRAY_DIM) : '0;
      assign col_off_o = phase_q[0] ? OFFW'(ARRAY_DIM) : '0;
    end
  endgenerate

endmodule

// File: rtl/seq_fill_timer.sv
module seq_fill_timer #(
  parameter int unsigned FILL_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic run,
  output logic ready_o
);

  localparam int unsigned CNTW = $clog2(FILL_CYCLES + 1);
  localparam logic [CNTW-1:0] LIMIT = CNTW'(FILL_CYCLES);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready_o = run && (cnt_q == LIMIT);

endmodule

// File: rtl/conv_phase_seq.sv
module conv_phase_seq
  import conv_seq_pkg::*;
#(
  parameter int unsigned NW          = 7,
  parameter int unsigned KW          = 5,
  parameter int unsigned ARRAY_DIM   = 8,
  parameter int unsigned FILL_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] cfg_img_n,
  input  logic [KW-1:0] cfg_ker_k,
  input  logic          load_ack,
  input  logic          kstr_ack,
  input  logic          conv_ack,
  input  logic          wb_ack,
  input  logic          drain_ack,
  output logic [2:0]    state_o,
  output logic          busy,
  output logic          res_valid,
  output logic [1:0]    phase_idx,
  output logic [2:0]    n_phases,
  output logic [KW-1:0] ker_row_off,
  output logic [KW-1:0] ker_col_off,
  output logic [NW-1:0] out_dim,
  output logic          done
);

  logic       rst_sync_n;
  seq_state_e state_q, state_d;
  logic       take_start;
  logic       phase_adv;
  logic       last_phase;
  logic       fill_ready;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_ni     (rst_n),
    .rst_sync_no(rst_sync_n)
  );

  assign take_start = (state_q == SEQ_IDLE) && start;
  assign phase_adv  = (state_q == SEQ_WB) && wb_ack && !last_phase;

  seq_cfg_latch #(.NW(NW), .KW(KW), .ARRAY_DIM(ARRAY_DIM)) u_cfg (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .capture   (take_start),
    .img_n     (cfg_img_n),
    .ker_k     (cfg_ker_k),
    .n_phases_o(n_phases),
    .out_dim_o (out_dim)
  );

  seq_phase_ctr #(.ARRAY_DIM(ARRAY_DIM), .OFFW(KW)) u_phase (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .clear    (take_start),
    .advance  (phase_adv),
    .n_phases (n_phases),
    .phase_o  (phase_idx),
    .last_o   (last_phase),
    .row_off_o(ker_row_off),
    .col_off_o(ker_col_off)
  );

  seq_fill_timer #(.FILL_CYCLES(FILL_CYCLES)) u_fill (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .run    (state_q == SEQ_CONV),
    .ready_o(fill_ready)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (start)                  state_d = SEQ_LOAD;
      SEQ_LOAD:  if (load_ack)               state_d = SEQ_KSTR;
      SEQ_KSTR:  if (kstr_ack)               state_d = SEQ_CONV;
      SEQ_CONV:  if (conv_ack && fill_ready) state_d = SEQ_WB;
      SEQ_WB:    if (wb_ack)                 state_d = last_phase ? SEQ_DRAIN : SEQ_KSTR;
      SEQ_DRAIN: if (drain_ack)              state_d = SEQ_DONE;
      SEQ_DONE:                              state_d = SEQ_IDLE;
      default:                               state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SEQ_IDLE;
    end else if (state_d != state_q) begin
      state_q <= state_d;
    end
  end

  assign state_o   = state_q;
  assign busy      = (state_q != SEQ_IDLE);
  assign res_valid = fill_ready;
  assign done      = (state_q == SEQ_DONE);

endmodule

// File: rtl/conv_phase_seq_chk.sv
module conv_phase_seq_chk
  import conv_seq_pkg::*;
#(
  parameter int unsigned KW        = 5,
  parameter int unsigned ARRAY_DIM = 8
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          start,
  input logic [2:0]    state_o,
  input logic          res_valid,
  input logic [1:0]    phase_idx,
  input logic [2:0]    n_phases,
  input logic [KW-1:0] ker_row_off,
  input logic [KW-1:0] ker_col_off,
  input logic          done
);

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_o == SEQ_IDLE && start) |=> (state_o == SEQ_LOAD));

  assert_load_exit_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_o == SEQ_LOAD) |=> (state_o == SEQ_LOAD || state_o == SEQ_KSTR));

  assert_fill_gate_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_o == SEQ_CONV && !res_valid) |=> (state_o == SEQ_CONV));

  assert_single_pass_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (n_phases == 3'd1) |-> (phase_idx == 2'd0));

  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_o != SEQ_IDLE && state_o != SEQ_WB) |=> $stable(phase_idx));

  assert_offsets_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ker_row_off == '0 || ker_row_off == KW'(ARRAY_DIM)) &&
    (ker_col_off == '0 || ker_col_off == KW'(ARRAY_DIM)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> (!done && state_o == SEQ_IDLE));

endmodule

bind conv_phase_seq conv_phase_seq_chk #(.KW(KW), .ARRAY_DIM(ARRAY_DIM)) chk_i (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .start      (start),
  .state_o    (state_o),
  .res_valid  (res_valid),
  .phase_idx  (phase_idx),
  .n_phases   (n_phases),
  .ker_row_off(ker_row_off),
  .ker_col_off(ker_col_off),
  .done       (done)
);

// File: tb/conv_phase_seq_tb_top.sv
module conv_phase_seq_tb_top;

  localparam int NVEC = 6;
  // columns: N, K, expected passes, expected output side
  localparam int VEC [NVEC][4] = '{
    '{64,  3, 1, 62},
    '{64, 16, 4, 49},
    '{10,  8, 1,  3},
    '{ 9,  9, 4,  1},
    '{ 5, 12, 4,  0},
    '{64,  1, 1, 64}
  };

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [6:0] cfg_img_n;
  logic [4:0] cfg_ker_k;
  logic       load_ack, kstr_ack, conv_ack, wb_ack, drain_ack;
  logic [2:0] state_o;
  logic       busy, res_valid, done;
  logic [1:0] phase_idx;
  logic [2:0] n_phases;
  logic [4:0] ker_row_off, ker_col_off;
  logic [6:0] out_dim;

  int errors = 0;
  int checks = 0;

  conv_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_img_n(cfg_img_n), .cfg_ker_k(cfg_ker_k),
    .load_ack(load_ack), .kstr_ack(kstr_ack), .conv_ack(conv_ack),
    .wb_ack(wb_ack), .drain_ack(drain_ack),
    .state_o(state_o), .busy(busy), .res_valid(res_valid),
    .phase_idx(phase_idx), .n_phases(n_phases),
    .ker_row_off(ker_row_off), .ker_col_off(ker_col_off),
    .out_dim(out_dim), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // 1=load 2=kstr 3=conv 4=wb 5=drain
  task automatic pulse(input int which);
    load_ack  = (which == 1);
    kstr_ack  = (which == 2);
    conv_ack  = (which == 3);
    wb_ack    = (which == 4);
    drain_ack = (which == 5);
    step();
    load_ack = 0; kstr_ack = 0; conv_ack = 0; wb_ack = 0; drain_ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step(); step(); step();
  endtask

  task automatic run_job(input int n, input int k, input int eph, input int edim);
    cfg_img_n = 7'(n);
    cfg_ker_k = 5'(k);
    start = 1;
    step();
    start = 0;
    chk("R2 state after start", state_o, 1);
    chk("R8 out_dim", out_dim, edim);
    chk("R8 n_phases", n_phases, eph);
    pulse(1);
    chk("R3 load->kstr", state_o, 2);
    for (int p = 0; p < eph; p++) begin
      chk("R6 phase_idx", phase_idx, p);
      chk("R6 row offset", ker_row_off, (p / 2) * 8);
      chk("R6 col offset", ker_col_off, (p % 2) * 8);
      pulse(2);
      chk("R3 kstr->conv", state_o, 3);
      for (int c = 0; c < 7; c++) step();
      chk("R4 res_valid before fill", res_valid, 0);
      step();
      chk("R4 res_valid after 8 edges", res_valid, 1);
      pulse(3);
      chk("R4 conv->wb", state_o, 4);
      pulse(4);
      if (p == eph - 1) chk("R5 wb->drain on last pass", state_o, 5);
      else              chk("R6 wb->kstr on inner pass", state_o, 2);
    end
    pulse(5);
    chk("R7 done state", state_o, 6);
    chk("R7 done high", done, 1);
    step();
    chk("R7 done one cycle", done, 0);
    chk("R7 back to idle", state_o, 0);
  endtask

  initial begin
    rst_n = 0; start = 0; cfg_img_n = 0; cfg_ker_k = 0;
    load_ack = 0; kstr_ack = 0; conv_ack = 0; wb_ack = 0; drain_ack = 0;
    step(); step();
    chk("R1 reset state", state_o, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset busy", busy, 0);
    rst_n = 1;
    step(); step(); step();
    chk("R1 idle after release", state_o, 0);
    chk("R1 phase after reset", phase_idx, 0);
    chk("R1 offsets after reset", {27'd0, ker_row_off} + {27'd0, ker_col_off}, 0);
    chk("R1 res_valid after reset", res_valid, 0);

    for (int v = 0; v < NVEC; v++) run_job(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // stray acks in idle
    pulse(1); pulse(3); pulse(5);
    chk("R3 stray acks in idle", state_o, 0);

    // stray acks in load; start while busy
    cfg_img_n = 7'd20; cfg_ker_k = 5'd4;
    start = 1; step(); start = 0;
    chk("R2 start K=4", state_o, 1);
    pulse(2); pulse(4); pulse(5); pulse(3);
    chk("R3 foreign acks in load", state_o, 1);
    pulse(1);
    cfg_img_n = 7'd64; cfg_ker_k = 5'd16;
    start = 1; step(); start = 0;
    chk("R2 start while busy state", state_o, 2);
    chk("R2 start while busy cfg", out_dim, 17);
    chk("R5 single pass for K=4", n_phases, 1);
    pulse(2);
    step(); step();
    pulse(3);
    chk("R4 early conv_ack ignored", state_o, 3);
    for (int c = 0; c < 6; c++) step();
    pulse(3);
    chk("R4 conv_ack after fill", state_o, 4);
    pulse(1); pulse(5);
    chk("R3 foreign acks in wb", state_o, 4);
    pulse(4);
    chk("R5 K=4 wb->drain", state_o, 5);
    pulse(5);
    chk("R7 done", done, 1);
    start = 1; step(); start = 0;
    chk("R2 start in done cycle ignored", state_o, 0);
    chk("R2 cfg kept after done-cycle start", out_dim, 17);

    // asynchronous reset mid-run
    cfg_img_n = 7'd32; cfg_ker_k = 5'd10;
    start = 1; step(); start = 0;
    pulse(1); pulse(2);
    chk("R9 in conv before reset", state_o, 3);
    #1 rst_n = 0;
    #0.5;
    chk("R9 asynchronous return to idle", state_o, 0);
    step();
    rst_n = 1;
    step(); step(); step();
    chk("R9 idle after reset release", state_o, 0);
    run_job(32, 10, 4, 23);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule